// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical scan counts, the data-enable strobe and the two sync pulses for a progressive video raster. Software sets the line and frame geometry as end positions in minus-one form. The active count is the visible size minus one. The sync-start count is the active count plus the front porch. The sync-end count is the sync-start count plus the pulse width. The total count is the sync-end count plus the back porch. The horizontal and vertical axes use the same scheme. A two-bit polarity field sets the asserted level of each sync. The blanking windows are not programmed on their own: blanking is whatever lies outside the active counts.

Control is a two-state machine. In state OFF the counters sit at zero, data-enable is low, both syncs are at their inactive level, and the shadow copy of the configuration follows the input ports every cycle. The transition "start" (OFF to RUN) happens on the edge where enable is seen high. The first RUN cycle then shows position (0,0). In state RUN the horizontal counter advances every pixel clock, and the vertical counter advances when a line wraps. The shadow configuration is reloaded only on the edge that closes a frame, so that the new geometry begins at the next frame. The transition "stop" (RUN to OFF) happens on the edge where enable is seen low. The counters clear on that same edge. An interlace request input is accepted, but the output is always progressive.

Top module: `raster_timer`

## Requirements
- R1: After reset, and during every cycle in state OFF, h_count and v_count read 0, de is 0, and each sync sits at its inactive level.
- R2: In RUN, h_count steps by one per clock from 0 up to the horizontal total, inclusive, and then returns to 0.
- R3: v_count advances only on the clock where h_count wraps. After it reaches the vertical total, it returns to 0 on the next wrap.
- R4: de is 1 exactly when h_count is at or below the horizontal active count and v_count is at or below the vertical active count.
- R5: The horizontal sync window covers h_count values strictly greater than the sync-start count, up to and including the sync-end count.
- R6: The vertical sync window follows the same rule on v_count, using the vertical sync-start and sync-end counts.
- R7: sync_pol bit 0 governs hsync and bit 1 governs vsync. A 1 makes the sync high inside its window and low outside it. A 0 gives the inverse.
- R8: A configuration change made while in RUN takes effect at the first cycle of the next frame (position 0,0), not earlier. While in OFF, the configuration inputs are taken in within one clock.
- R9: The first cycle after the edge that samples enable high shows position (0,0). The first cycle after the edge that samples enable low shows the OFF outputs of R1.
- R10: The interlace input has no effect on the counts or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run request |
| interlace | input | 1 | Interlace request, ignored |
| h_total | input | CW | Last horizontal position of a line |
| h_active | input | CW | Last visible horizontal position |
| h_sync_start | input | CW | Horizontal position just before hsync begins |
| h_sync_end | input | CW | Last horizontal position inside hsync |
| v_total | input | CW | Last line of a frame |
| v_active | input | CW | Last visible line |
| v_sync_start | input | CW | Line just before vsync begins |
| v_sync_end | input | CW | Last line inside vsync |
| sync_pol | input | 2 | Bit 1 vsync, bit 0 hsync; 1 means active-high |
| h_count | output | CW | Horizontal position |
| v_count | output | CW | Vertical position |
| de | output | 1 | Data-enable (visible pixel) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
Three events can fall on the same clock edge: the line wrap, the frame wrap and the shadow reload. On the final pixel of a frame, the horizontal wrap, the vertical wrap and the configuration reload all happen at once. The bench changes the line length in mid-frame. It then checks that the last pixel of the current frame still uses the old total, and that the first line of the next frame runs to the new total. A second coincidence is the stop request landing on a mid-line position. The bench checks that the counters clear on that same edge, and not at the end of the line.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic {
        RT_OFF = 1'b0,
        RT_RUN = 1'b1
    } rt_state_e;

    localparam int RT_AXIS_FIELDS = 4;
endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
    import rt_pkg::*;
#(
    parameter int CFG_W = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             frame_end,
    input  logic [CFG_W-1:0] cfg_in,
    output logic             run,
    output logic             go,
    output logic [CFG_W-1:0] cfg_sh
);
    rt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RT_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_OFF: if (en)  state_d = RT_RUN;   // start
            RT_RUN: if (!en) state_d = RT_OFF;   // stop
        endcase
    end

    always_comb begin
        run = (state_q == RT_RUN);
        go  = run && en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_sh <= '0;
        else if (state_q == RT_OFF || (go && frame_end))
            cfg_sh <= cfg_in;
    end

    // R8: shadow stays put inside a running frame
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !frame_end) |=> $stable(cfg_sh));
    // R9: a stop request leaves the run state on the next edge
    p_stop_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en) |=> !run);
endmodule

// File: rtl/rt_axis.sv
module rt_axis #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] total,
    input  logic [CW-1:0] active,
    input  logic [CW-1:0] sstart,
    input  logic [CW-1:0] send,
    input  logic          pol,
    output logic [CW-1:0] cnt,
    output logic          last,
    output logic          in_act,
    output logic          sync
);
    logic window;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!go)     cnt <= '0;
        else if (step)    cnt <= last ? '0 : cnt + 1'b1;
    end

    always_comb begin
        last   = (cnt == total);
        in_act = (cnt <= active);
        window = run && (cnt > sstart) && (cnt <= send);
        sync   = window ~^ pol;
    end

    // R2 (and R3 for the vertical instance): wrap to zero after the total
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && step && last) |=> (cnt == '0));
    // R2: single-step advance below the total
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && step && !last) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import rt_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          interlace,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] h_active,
    input  logic [CW-1:0] h_sync_start,
    input  logic [CW-1:0] h_sync_end,
    input  logic [CW-1:0] v_total,
    input  logic [CW-1:0] v_active,
    input  logic [CW-1:0] v_sync_start,
    input  logic [CW-1:0] v_sync_end,
    input  logic [1:0]    sync_pol,
    output logic [CW-1:0] h_count,
    output logic [CW-1:0] v_count,
    output logic          de,
    output logic          hsync,
    output logic          vsync
);
    localparam int AXW   = RT_AXIS_FIELDS * CW;
    localparam int CFG_W = 2 * AXW + 2;

    logic             unused_interlace;
    logic [CFG_W-1:0] cfg_in, cfg_sh;
    logic             run, go, h_last, v_last, h_in, v_in;

    assign unused_interlace = interlace;
    assign cfg_in = {sync_pol,
                     v_sync_end, v_sync_start, v_active, v_total,
                     h_sync_end, h_sync_start, h_active, h_total};

    rt_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en),
        .frame_end(h_last && v_last),
        .cfg_in(cfg_in), .run(run), .go(go), .cfg_sh(cfg_sh)
    );

    logic [CW-1:0] ax_cnt  [2];
    logic          ax_last [2];
    logic          ax_in   [2];
    logic          ax_sync [2];

    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam int BASE = a * AXW;
        rt_axis #(.CW(CW)) u_axis (
            .clk(clk), .rst_n(rst_n), .go(go), .run(run),
            .step((a == 0) ? 1'b1 : h_last),
            .total (cfg_sh[BASE        +: CW]),
            .active(cfg_sh[BASE +   CW +: CW]),
            .sstart(cfg_sh[BASE + 2*CW +: CW]),
            .send  (cfg_sh[BASE + 3*CW +: CW]),
            .pol   (cfg_sh[2*AXW + a]),
            .cnt(ax_cnt[a]), .last(ax_last[a]), .in_act(ax_in[a]), .sync(ax_sync[a])
        );
    end

    always_comb begin
        h_count = ax_cnt[0];
        v_count = ax_cnt[1];
        h_last  = ax_last[0];
        v_last  = ax_last[1];
        h_in    = ax_in[0];
        v_in    = ax_in[1];
        de      = run && h_in && v_in;
        hsync   = ax_sync[0];
        vsync   = ax_sync[1];
    end

    // R1: idle outputs while not running
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (h_count == '0 && v_count == '0 && !de));
    // R3: vertical position only moves on a line wrap
    p_vhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !h_last) |=> $stable(v_count));
    // R9: stop clears the position on the very next edge
    p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en) |=> (h_count == '0 && v_count == '0));
endmodule

// File: tb/sim_raster_timer.sv
module sim_raster_timer;
    localparam int CW = 12;

    logic clk = 0, rst_n = 0, en = 0, interlace = 0;
    logic [CW-1:0] h_total, h_active, h_sync_start, h_sync_end;
    logic [CW-1:0] v_total, v_active, v_sync_start, v_sync_end;
    logic [1:0] sync_pol;
    logic [CW-1:0] h_count, v_count;
    logic de, hsync, vsync;

    int n_chk = 0, n_bad = 0, k = 0;
    bit done = 0;

    always #5 clk = ~clk;

    raster_timer #(.CW(CW)) u0 (.*);

    // {cycle, h, v, pad, de, hsync, vsync} for h: 3/4/6/7, v: 2/3/4/5, pol 01
    localparam logic [23:0] VEC [15] = '{
        {8'd0,  4'd0, 4'd0, 5'd0, 3'b101},
        {8'd3,  4'd3, 4'd0, 5'd0, 3'b101},
        {8'd4,  4'd4, 4'd0, 5'd0, 3'b001},
        {8'd5,  4'd5, 4'd0, 5'd0, 3'b011},
        {8'd6,  4'd6, 4'd0, 5'd0, 3'b011},
        {8'd7,  4'd7, 4'd0, 5'd0, 3'b001},
        {8'd8,  4'd0, 4'd1, 5'd0, 3'b101},
        {8'd19, 4'd3, 4'd2, 5'd0, 3'b101},
        {8'd24, 4'd0, 4'd3, 5'd0, 3'b001},
        {8'd29, 4'd5, 4'd3, 5'd0, 3'b011},
        {8'd32, 4'd0, 4'd4, 5'd0, 3'b000},
        {8'd37, 4'd5, 4'd4, 5'd0, 3'b010},
        {8'd40, 4'd0, 4'd5, 5'd0, 3'b001},
        {8'd47, 4'd7, 4'd5, 5'd0, 3'b001},
        {8'd48, 4'd0, 4'd0, 5'd0, 3'b101}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (k=%0d)", tag, act, exp, k);
        end
    endtask

    task automatic adv(input int target);
        while (k < target) begin
            @(posedge clk); @(negedge clk); k++;
        end
    endtask

    task automatic start_run;
        en = 1;
        @(posedge clk); @(negedge clk);
        k = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        h_total = 7; h_active = 3; h_sync_start = 4; h_sync_end = 6;
        v_total = 5; v_active = 2; v_sync_start = 3; v_sync_end = 4;
        sync_pol = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); @(negedge clk);
        chk("R1 reset h_count", h_count, 0);
        chk("R1 reset v_count", v_count, 0);
        chk("R1 reset de", de, 0);
        chk("R1 reset hsync", hsync, 0);
        chk("R1 reset vsync", vsync, 1);

        // table walk over one frame plus wrap (R2..R7, R9 first cycle)
        start_run;
        for (int i = 0; i < 15; i++) begin
            adv(int'(VEC[i][23:16]));
            chk("R2 h_count", h_count, int'(VEC[i][15:12]));
            chk("R3 v_count", v_count, int'(VEC[i][11:8]));
            chk("R4 de", de, int'(VEC[i][2]));
            chk("R5 R7 hsync", hsync, int'(VEC[i][1]));
            chk("R6 R7 vsync", vsync, int'(VEC[i][0]));
        end

        // R8: line length change mid-frame waits for the next frame
        h_total = 9;
        adv(56);
        chk("R8 old total h", h_count, 0);
        chk("R8 old total v", v_count, 1);
        adv(95);
        chk("R8 frame end h", h_count, 7);
        chk("R8 frame end v", v_count, 5);
        adv(96);
        chk("R8 new frame h", h_count, 0);
        chk("R8 new frame v", v_count, 0);
        adv(104);
        chk("R8 new total h", h_count, 8);
        chk("R8 new total v", v_count, 0);
        adv(106);
        chk("R8 new wrap v", v_count, 1);
        adv(108);
        chk("R9 pre-stop h", h_count, 2);

        // R9: stop mid-line clears on the next edge
        en = 0;
        @(posedge clk); @(negedge clk);
        chk("R9 stop h", h_count, 0);
        chk("R9 stop v", v_count, 0);
        chk("R9 stop de", de, 0);
        chk("R9 stop hsync", hsync, 0);
        chk("R9 stop vsync", vsync, 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 hold h", h_count, 0);
        chk("R1 hold de", de, 0);

        // R7 / R10: inverted polarity, interlace set
        sync_pol = 2'b10; interlace = 1; h_total = 7;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 idle hsync low-active", hsync, 1);
        chk("R7 idle vsync high-active", vsync, 0);
        chk("R8 off follow (via R1 de)", de, 0);
        start_run;
        chk("R9 start h", h_count, 0);
        chk("R7 k0 hsync", hsync, 1);
        chk("R7 k0 vsync", vsync, 0);
        adv(5);
        chk("R7 hsync asserted low", hsync, 0);
        adv(8);
        chk("R10 interlace h", h_count, 0);
        chk("R10 interlace v", v_count, 1);
        chk("R10 interlace de", de, 1);
        adv(32);
        chk("R7 vsync asserted high", vsync, 1);
        chk("R10 interlace v4", v_count, 4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule